// File: doc/BRIEF.md
# GPIO Port with Pin-Change Interrupt

This block is an 8-pin bidirectional general-purpose I/O port that sits on a small synchronous register bus. Each pin has a direction bit and an output latch bit, and the block drives the pad's tri-state enable, output value and weak pull-up enable. Software reads the pin levels through a port register and reads the latched output values through a separate latch register. Because the latch reads back its own value and not the pin, read-modify-write on outputs stays correct.

Pin inputs pass through a two-flop synchronizer before anything uses them. At reset the low five pins are treated as analog and read as zero, unless a configuration input selects digital mode. A control bit can change this later.

The upper four pins are watched for changes. Every read or write of the port register captures their synchronized levels into a snapshot. Each of these pins that is configured as an input is compared with its snapshot. Any difference sets a sticky change flag, and the flag is set again on every cycle while the difference lasts. To clear it, software reads the port, waits one cycle, and then writes 0 to the flag. An enable bit gates the flag onto an interrupt output, which can also act as a wake request.

Top module: `gpio_chg_port`

## Requirements
- R1: Direction register (address 2) resets to all ones. A 1 makes the pin an input with `pad_oe` low. A 0 drives `pad_oe` high, with the latch bit on `pad_out`.
- R2: A write to address 0 (port) or address 1 (latch) loads the output latch, shown on `pad_out`. A read of address 1 returns the latch, not the pin level.
- R3: Control bit 7 is an active-low global pull-up enable and resets to 1. `pad_pu[i]` is high only when bit 7 is 0 and pin i is an input.
- R4: A read of address 0 returns the pin levels delayed by a two-flop synchronizer.
- R5: Control bit 2 set forces pins 4..0 to read 0 through address 0. It resets to the inverse of `cfg_digital_low`.
- R6: Only pins 7..4 configured as inputs take part in change detection. A difference between one of them and its snapshot sets the change flag (control bit 0) on the next cycle. Output pins and pins 3..0 never set it.
- R7: While a difference persists, writing 0 to the flag has no effect and the flag stays 1.
- R8: Any read or write of address 0 loads the snapshot from the synchronized pins. After a port access, a flag clear one cycle later leaves the flag at 0.
- R9: `irq` equals the change flag ANDed with control bit 1 (interrupt enable).
- R10: Read data is registered. It appears on `bus_rdata` the cycle after `bus_re` and is held until the next read.
- R11: The control register reads back bit 7 pull-up disable, bit 2 analog-low, bit 1 interrupt enable and bit 0 flag, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_digital_low | input | 1 | 1: low pins come out of reset digital |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt / wake request |

## Verification
On every cycle the assertions check four things:
- A pull-up is never enabled on a pin that drives its output.
- Direction and latch writes reach the pads one cycle later.
- The snapshot follows each port access.
- A live difference always leaves the flag set, and a clear with no difference leaves it at 0.

Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the synchronizer delay on port reads and the analog read-as-zero masking under both reset configurations. It also covers masking of output pins and low pins from change detection, and the read-wait-clear sequence that ends an interrupt.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
   typedef enum logic [1:0] {
      REG_PORT = 2'd0,
      REG_LAT  = 2'd1,
      REG_DIR  = 2'd2,
      REG_CTRL = 2'd3
   } gpio_reg_e;

   localparam int CTRL_FLAG = 0;
   localparam int CTRL_IE   = 1;
   localparam int CTRL_ANA  = 2;
   localparam int CTRL_PUD  = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_chg_pkg::*;
#(
   parameter int W       = 8,
   parameter int ANA_CNT = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_digital_low,
   input  logic [1:0]   addr,
   input  logic         we,
   input  logic         re,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_sync,
   input  logic         chg_flag,
   output logic [W-1:0] rdata,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] dir_q,
   output logic         pud_q,
   output logic         ana_q,
   output logic         ie_q
);
   logic [W-1:0] ana_mask;
   logic [W-1:0] ctrl_view;
   logic [W-1:0] rd_next;

   if (ANA_CNT > W) begin : g_bad_ana
      $error("gpio_regs: ANA_CNT exceeds port width");
   end

   for (genvar i = 0; i < W; i++) begin : g_mask
      assign ana_mask[i] = (i < ANA_CNT) ? ana_q : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '1;
         pud_q <= 1'b1;
         ana_q <= ~cfg_digital_low;
         ie_q  <= 1'b0;
      end else if (we) begin
         case (gpio_reg_e'(addr))
            REG_PORT, REG_LAT: lat_q <= wdata;
            REG_DIR:           dir_q <= wdata;
            REG_CTRL: begin
               pud_q <= wdata[CTRL_PUD];
               ana_q <= wdata[CTRL_ANA];
               ie_q  <= wdata[CTRL_IE];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      ctrl_view            = '0;
      ctrl_view[CTRL_PUD]  = pud_q;
      ctrl_view[CTRL_ANA]  = ana_q;
      ctrl_view[CTRL_IE]   = ie_q;
      ctrl_view[CTRL_FLAG] = chg_flag;
      case (gpio_reg_e'(addr))
         REG_PORT: rd_next = pin_sync & ~ana_mask;
         REG_LAT:  rd_next = lat_q;
         REG_DIR:  rd_next = dir_q;
         default:  rd_next = ctrl_view;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_next;
   end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
   parameter int W      = 8,
   parameter int CHG_LO = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        pin_sync,
   input  logic [W-1:0]        dir_q,
   input  logic                port_access,
   input  logic                flag_we,
   input  logic                flag_wval,
   output logic [W-CHG_LO-1:0] snap_q,
   output logic                mismatch,
   output logic                flag_q
);
   localparam int NCHG = W - CHG_LO;

   logic [NCHG-1:0] live;
   logic [NCHG-1:0] diff;

   if (CHG_LO < 0 || CHG_LO >= W) begin : g_bad_lo
      $error("gpio_chg_det: CHG_LO out of range");
   end

   for (genvar i = 0; i < NCHG; i++) begin : g_cmp
      assign live[i] = pin_sync[CHG_LO+i];
      assign diff[i] = (live[i] ^ snap_q[i]) & dir_q[CHG_LO+i];
   end

   assign mismatch = |diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           snap_q <= '0;
      else if (port_access) snap_q <= live;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (mismatch) flag_q <= 1'b1;
      else if (flag_we)  flag_q <= flag_wval;
   end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
   import gpio_chg_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ANA_CNT     = 5,
   parameter int CHG_LO      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_digital_low,
   input  logic [1:0]   bus_addr,
   input  logic         bus_we,
   input  logic         bus_re,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_pu,
   output logic         irq
);
   localparam int NCHG = W - CHG_LO;

   if (W < CTRL_PUD + 1) begin : g_bad_w
      $error("gpio_chg_port: W too small for control layout");
   end

   logic [W-1:0]    pin_sync;
   logic [W-1:0]    lat_q;
   logic [W-1:0]    dir_q;
   logic            pud_q;
   logic            ana_q;
   logic            ie_q;
   logic [NCHG-1:0] chg_snap;
   logic            chg_mismatch;
   logic            chg_flag;
   logic            port_access;
   logic            ctrl_we;

   assign port_access = (bus_re | bus_we) && (gpio_reg_e'(bus_addr) == REG_PORT);
   assign ctrl_we     = bus_we && (gpio_reg_e'(bus_addr) == REG_CTRL);

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   gpio_regs #(.W(W), .ANA_CNT(ANA_CNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_digital_low(cfg_digital_low),
      .addr(bus_addr), .we(bus_we), .re(bus_re), .wdata(bus_wdata),
      .pin_sync(pin_sync), .chg_flag(chg_flag), .rdata(bus_rdata),
      .lat_q(lat_q), .dir_q(dir_q), .pud_q(pud_q), .ana_q(ana_q), .ie_q(ie_q)
   );

   gpio_chg_det #(.W(W), .CHG_LO(CHG_LO)) u_chg (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_q(dir_q),
      .port_access(port_access), .flag_we(ctrl_we),
      .flag_wval(bus_wdata[CTRL_FLAG]), .snap_q(chg_snap),
      .mismatch(chg_mismatch), .flag_q(chg_flag)
   );

   assign pad_out = lat_q;
   assign pad_oe  = ~dir_q;
   assign pad_pu  = dir_q & {W{~pud_q}};
   assign irq     = chg_flag & ie_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
   import gpio_chg_pkg::*;
#(
   parameter int W      = 8,
   parameter int CHG_LO = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          bus_addr,
   input logic                bus_we,
   input logic                bus_re,
   input logic [W-1:0]        bus_wdata,
   input logic [W-1:0]        pad_out,
   input logic [W-1:0]        pad_oe,
   input logic [W-1:0]        pad_pu,
   input logic [W-1:0]        pin_sync,
   input logic [W-CHG_LO-1:0] chg_snap,
   input logic                chg_mismatch,
   input logic                chg_flag
);
   assert_pu_off_on_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0);

   assert_dir_to_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == REG_DIR) |=> (pad_oe == ~$past(bus_wdata)));

   assert_latch_to_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == REG_PORT || bus_addr == REG_LAT)) |=> (pad_out == $past(bus_wdata)));

   assert_snap_on_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_we || bus_re) && bus_addr == REG_PORT) |=> (chg_snap == $past(pin_sync[W-1:CHG_LO])));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chg_mismatch |=> chg_flag);

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == REG_CTRL && !bus_wdata[CTRL_FLAG] && !chg_mismatch) |=> !chg_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .CHG_LO(CHG_LO)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
   .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
   .pin_sync(pin_sync), .chg_snap(chg_snap), .chg_mismatch(chg_mismatch),
   .chg_flag(chg_flag)
);

// File: tb/tb_gpio_chg_port.sv
module tb_gpio_chg_port;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       cfg_digital_low = 0;
   logic [1:0] bus_addr = 0;
   logic       bus_we = 0, bus_re = 0;
   logic [7:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe, pad_pu;
   logic       irq;

   int tests = 0, fails = 0;
   bit done = 0;

   gpio_chg_port dut (.*);

   always #5 clk = ~clk;

   // behavioural reference model
   logic [7:0] h0, h1, m_lat, m_dir, m_rd;
   logic [3:0] m_snap;
   logic m_pud, m_ana, m_ie, m_flag;

   function automatic logic [7:0] m_port();
      return h1 & (m_ana ? 8'h1F : 8'h00);
   endfunction

   function automatic logic [7:0] model_port();
      return h1 & ~(m_ana ? 8'h1F : 8'h00);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 <= 0; h1 <= 0; m_lat <= 0; m_dir <= 8'hFF; m_rd <= 0; m_snap <= 0;
         m_pud <= 1; m_ana <= !cfg_digital_low; m_ie <= 0; m_flag <= 0;
      end else begin
         logic chg;
         chg = |((h1[7:4] ^ m_snap) & m_dir[7:4]);
         h0 <= pad_in; h1 <= h0;
         if (bus_re) begin
            case (bus_addr)
               0: m_rd <= model_port();
               1: m_rd <= m_lat;
               2: m_rd <= m_dir;
               default: m_rd <= {m_pud, 4'b0, m_ana, m_ie, m_flag};
            endcase
         end
         if ((bus_re || bus_we) && bus_addr == 0) m_snap <= h1[7:4];
         if (bus_we) begin
            if (bus_addr <= 1) m_lat <= bus_wdata;
            if (bus_addr == 2) m_dir <= bus_wdata;
            if (bus_addr == 3) begin
               m_pud <= bus_wdata[7]; m_ana <= bus_wdata[2]; m_ie <= bus_wdata[1];
            end
         end
         if (chg) m_flag <= 1;
         else if (bus_we && bus_addr == 3) m_flag <= bus_wdata[0];
      end
   end

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check("R10/R4 rdata", bus_rdata, m_rd);
         check("R2 pad_out", pad_out, m_lat);
         check("R1 pad_oe", pad_oe, ~m_dir);
         check("R3 pad_pu", pad_pu, m_dir & {8{~m_pud}});
         check("R9 irq", {7'b0, irq}, {7'b0, m_flag & m_ie});
      end
   end

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_re = 1;
      @(negedge clk); bus_re = 0; d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(logic cfg);
      @(negedge clk); rst_n = 0; cfg_digital_low = cfg;
      idle(2); rst_n = 1; idle(1);
   endtask

   initial begin
      #200000;
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      do_reset(0);
      // R11 R3 R5 reset control state, R1 reset direction
      rd(3, v); check("R11 reset ctrl", v, 8'h84);
      check("R1 reset oe", pad_oe, 8'h00);
      check("R3 reset pu", pad_pu, 8'h00);
      rd(2, v); check("R1 reset dir", v, 8'hFF);
      // R5 analog low pins read zero, R4 sync
      pad_in = 8'hFF; idle(3);
      rd(0, v); check("R5 analog read", v, 8'hE0);
      wr(3, 8'h80);
      rd(0, v); check("R4 port read", v, 8'hFF);
      // R2 latch read-back independent of pins
      wr(1, 8'hA5); wr(2, 8'hCF);
      check("R1 oe", pad_oe, 8'h30);
      check("R2 pad_out", pad_out, 8'hA5);
      rd(1, v); check("R2 latch read", v, 8'hA5);
      wr(0, 8'h3C); rd(1, v); check("R2 port write to latch", v, 8'h3C);
      // R3 pull-ups on inputs only
      wr(3, 8'h00); check("R3 pu enabled", pad_pu, 8'hCF);
      // R6 change detect, R9 irq
      wr(2, 8'hFF); rd(0, v); idle(1);
      wr(3, 8'h02);
      pad_in = 8'hBF; idle(4);
      check("R9 irq set", {7'b0, irq}, 8'h01);
      // R7 clear ignored while mismatch
      wr(3, 8'h02); rd(3, v); check("R7 flag persists", v, 8'h03);
      // R8 read, wait, clear
      rd(0, v); idle(1); wr(3, 8'h02); rd(3, v); check("R8 flag cleared", v, 8'h02);
      // R6 output pin and low pin excluded
      wr(2, 8'h7F);
      pad_in = 8'h3E; idle(5);
      rd(3, v); check("R6 masked pins", v, 8'h02);
      // R8 write to port refreshes snapshot
      wr(2, 8'hFF); rd(0, v); idle(1); wr(3, 8'h02);
      rd(3, v); check("R8 clean after read", v, 8'h02);
      pad_in = 8'h1E; idle(4);
      rd(3, v); check("R6 pin5 change", v, 8'h03);
      wr(0, 8'h00); wr(3, 8'h02);
      rd(3, v); check("R8 write refreshes snapshot", v, 8'h02);
      // R5 digital configuration at reset
      do_reset(1);
      rd(3, v); check("R5 digital reset ctrl", v, 8'h80);
      idle(3);
      rd(0, v); check("R5 digital low read", v, 8'h1E);
      idle(2);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule